// File: doc/BRIEF.md
# Floating-Point Issue Scoreboard

This block decides, one cycle at a time, whether the instruction offered to a floating-point unit may start. The unit has seven operation classes. Each class has a fixed latency and a minimum gap between two starts of that class. The block keeps one pending-write bit for each architectural register and holds a candidate in any of these cases:

- it would read a register that is still awaiting its result;
- it would overwrite such a register;
- its class is still inside its start gap;
- its result would land on the single writeback port in a cycle that is already taken.

When an instruction is granted, the block marks its destination as pending. It also schedules a writeback strobe that fires exactly one latency later and carries the register number. The pending bit is cleared at the end of that strobe cycle. The block computes no arithmetic. It only orders starts and completions, so that a front end can offer one instruction per cycle and move on when the grant is seen.

Operation class codes on `in_op`, with latency and start gap in cycles:

| Code | Class | Latency | Start gap |
|------|-------|---------|-----------|
| 0 | add/sub | 4 | 3 |
| 1 | multiply | 8 | 4 |
| 2 | divide | 36 | 35 |
| 3 | square root | 112 | 111 |
| 4 | negate | 2 | 1 |
| 5 | absolute value | 2 | 1 |
| 6 | compare | 3 | 2 |
| 7 | reserved | — | — |

Top module: `fp_issue_scoreboard`

## Requirements
- R1: While `rst_n` is low, `issue_grant` stays 0 for every input. After reset, no register is pending, no start gap is active and `wb_valid` is 0.
- R2: A grant in cycle t with class latency L (per the table above) produces `wb_valid`=1 with `wb_reg` equal to the granted destination in cycle t+L, and in no other cycle.
- R3: After a grant of a class whose start gap is G, that same class is held in cycles t+1 to t+G-1 and may be granted again from cycle t+G onward.
- R4: A candidate is held while the register on `in_src_a` is pending. For classes 0, 1, 2 and 6, it is also held while the register on `in_src_b` is pending.
- R5: Classes 3, 4 and 5 read one operand only. For these classes `in_src_b` has no effect on the grant.
- R6: A candidate is held while its destination `in_dst` is pending.
- R7: A pending register stays pending through its writeback strobe cycle. It blocks a candidate in that cycle and no longer blocks one in the next cycle.
- R8: A candidate whose completion cycle (now plus its latency) equals the completion cycle of an instruction already granted is held. The earlier instruction keeps that writeback slot.
- R9: Class code 7 is never granted.
- R10: `issue_grant` is 0 whenever `in_valid` is 0.
- R11: Start gaps are tracked per class. A busy class does not hold a different class.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | An instruction is offered this cycle |
| in_op | input | 3 | Operation class code (see table) |
| in_src_a | input | 5 | First source register number |
| in_src_b | input | 5 | Second source register number |
| in_dst | input | 5 | Destination register number |
| issue_grant | output | 1 | Combinational: the offered instruction starts this cycle |
| wb_valid | output | 1 | A result is written back this cycle |
| wb_reg | output | 5 | Register number of the result being written back |

## Verification
The bench sweeps each offset after a producer is granted, up to and past its strobe cycle. It does this for both operand positions, so a design that clears a pending bit one cycle early or late, or that ignores the second operand, grants at the wrong offset. For every class it also retries the same class on each cycle of its start gap. An off-by-one gap counter shows up as a grant one cycle early or late.

A reference model in the bench follows every grant and expects each strobe in its exact cycle with the right register. This catches a writeback wheel that is misaligned, and collision checking that looks at the wrong slot; such a fault lets two results compete for one port or strands a strobe. Single-operand classes are offered with a pending second source, the reserved code is offered with everything free, and different classes are started back to back. These catch decoding faults that would wrongly hold or wrongly grant.

// File: rtl/fp_sb_pkg.sv
// Package: operation class codes and per-class timing for the issue scoreboard.
// Assumes latencies and start gaps are fixed per class and known at design time.
package fp_sb_pkg;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_MUL  = 3'd1,
        OP_DIV  = 3'd2,
        OP_SQRT = 3'd3,
        OP_NEG  = 3'd4,
        OP_ABS  = 3'd5,
        OP_CMP  = 3'd6,
        OP_RSVD = 3'd7
    } fp_op_e;

    localparam int NUM_CLASS = 7;
    localparam int MAX_LAT   = 112;
    localparam int MAX_II    = 111;
    localparam int LAT_W     = $clog2(MAX_LAT + 1);
    localparam int CNT_W     = $clog2(MAX_II + 1);

    // Result latency of a class in cycles (0 for the reserved code).
    function automatic int unsigned lat_of(fp_op_e op);
        case (op)
            OP_ADD:  return 4;
            OP_MUL:  return 8;
            OP_DIV:  return 36;
            OP_SQRT: return 112;
            OP_NEG:  return 2;
            OP_ABS:  return 2;
            OP_CMP:  return 3;
            default: return 0;
        endcase
    endfunction

    // Minimum number of cycles between two starts of the same class.
    function automatic int unsigned ii_of(fp_op_e op);
        case (op)
            OP_ADD:  return 3;
            OP_MUL:  return 4;
            OP_DIV:  return 35;
            OP_SQRT: return 111;
            OP_NEG:  return 1;
            OP_ABS:  return 1;
            OP_CMP:  return 2;
            default: return 1;
        endcase
    endfunction

    // True when the class consumes its second operand.
    function automatic logic reads_b(fp_op_e op);
        case (op)
            OP_ADD, OP_MUL, OP_DIV, OP_CMP: return 1'b1;
            default:                        return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/fp_resv_table.sv
// Reservation table: one pending-write bit per register.
// Set on a grant, cleared at the end of the result's strobe cycle.
// Assumes set and clear never name the same register in one cycle; the
// top module never grants a pending destination, so this holds.
module fp_resv_table #(
    parameter int NREGS = 32,
    parameter int REG_W = $clog2(NREGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic [REG_W-1:0] set_reg,
    input  logic             clr_en,
    input  logic [REG_W-1:0] clr_reg,
    input  logic [REG_W-1:0] rd_a,
    input  logic [REG_W-1:0] rd_b,
    input  logic [REG_W-1:0] rd_d,
    output logic             hit_a,
    output logic             hit_b,
    output logic             hit_d
);

    logic [NREGS-1:0] pend;

    for (genvar r = 0; r < NREGS; r++) begin : g_reg
        // Update one register's pending bit.
        always_ff @(posedge clk) begin
            if (!rst_n)
                pend[r] <= 1'b0;
            else if (set_en && set_reg == REG_W'(r))
                pend[r] <= 1'b1;
            else if (clr_en && clr_reg == REG_W'(r))
                pend[r] <= 1'b0;
        end
    end

    // Look up the three operands of the candidate.
    always_comb begin
        hit_a = pend[rd_a];
        hit_b = pend[rd_b];
        hit_d = pend[rd_d];
    end

endmodule

// File: rtl/fp_ii_tracker.sv
// Start-gap tracker: one down-counter per operation class.
// Loaded with gap-1 when its class starts; the class is held while the
// counter is nonzero. Assumes at most one start per cycle.
module fp_ii_tracker
    import fp_sb_pkg::*;
#(
    parameter int NCLS = NUM_CLASS
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    input  fp_op_e op,
    output logic   hold
);

    logic [NCLS-1:0] busy;

    for (genvar c = 0; c < NCLS; c++) begin : g_cls
        localparam fp_op_e CLS = fp_op_e'(3'(c));
        logic [CNT_W-1:0] cnt;

        // Reload on a start of this class, otherwise count down to zero.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cnt <= '0;
            else if (start && op == CLS)
                cnt <= CNT_W'(ii_of(CLS) - 1);
            else if (cnt != '0)
                cnt <= cnt - 1'b1;
        end

        assign busy[c] = (cnt != '0);
    end

    // Select the busy flag of the candidate's class.
    always_comb begin
        hold = 1'b0;
        for (int c = 0; c < NCLS; c++)
            if (op == fp_op_e'(3'(c)) && busy[c])
                hold = 1'b1;
    end

endmodule

// File: rtl/fp_wb_wheel.sv
// Writeback wheel: slot k holds the result that completes k cycles from now.
// Every cycle it shifts toward slot 0, which drives the writeback strobe.
// A start with latency L is written into slot L-1 after the shift. The
// slot a candidate would occupy is slot L now, so that slot is reported
// as a collision. Assumes 1 <= ins_lat <= DEPTH-1 whenever ins_en is set.
module fp_wb_wheel #(
    parameter int REG_W = 5,
    parameter int DEPTH = 113,
    parameter int LAT_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LAT_W-1:0] ins_lat,
    input  logic             ins_en,
    input  logic [REG_W-1:0] ins_reg,
    output logic             collide,
    output logic             wb_valid,
    output logic [REG_W-1:0] wb_reg
);

    logic [DEPTH-1:0] slot_v;
    logic [REG_W-1:0] slot_r [DEPTH];

    // Advance the occupancy flags and place a new start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_v <= '0;
        end else begin
            slot_v <= {1'b0, slot_v[DEPTH-1:1]};
            if (ins_en)
                slot_v[ins_lat - 1'b1] <= 1'b1;
        end
    end

    // Advance the register tags alongside the flags (tags need no reset).
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH - 1; i++)
            slot_r[i] <= slot_r[i + 1];
        slot_r[DEPTH-1] <= '0;
        if (ins_en)
            slot_r[ins_lat - 1'b1] <= ins_reg;
    end

    // Report whether the candidate's completion slot is already taken.
    always_comb begin
        collide = (ins_lat < LAT_W'(DEPTH)) ? slot_v[ins_lat] : 1'b1;
    end

    assign wb_valid = slot_v[0];
    assign wb_reg   = slot_r[0];

endmodule

// File: rtl/fp_issue_scoreboard.sv
// Issue scoreboard for a multi-class floating-point unit.
// Combines the operand hazard checks (read-after-write on the sources,
// write-after-write on the destination), the per-class start gap and the
// writeback-slot collision into one combinational grant. It also
// schedules each granted result on a single writeback port.
// Assumes the caller holds its instruction until the grant is seen.
module fp_issue_scoreboard
    import fp_sb_pkg::*;
#(
    parameter int NREGS = 32,
    parameter int REG_W = $clog2(NREGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [2:0]       in_op,
    input  logic [REG_W-1:0] in_src_a,
    input  logic [REG_W-1:0] in_src_b,
    input  logic [REG_W-1:0] in_dst,
    output logic             issue_grant,
    output logic             wb_valid,
    output logic [REG_W-1:0] wb_reg
);

    localparam int DEPTH = MAX_LAT + 1;

    fp_op_e           op;
    logic [LAT_W-1:0] lat;
    logic             legal;
    logic             hit_a, hit_b, hit_d;
    logic             gap_hold, slot_busy;
    logic             raw_hz, waw_hz;

    // Decode the class of the candidate.
    always_comb begin
        op    = fp_op_e'(in_op);
        lat   = LAT_W'(lat_of(op));
        legal = (op != OP_RSVD);
    end

    fp_resv_table #(.NREGS(NREGS), .REG_W(REG_W)) u_resv (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (issue_grant),
        .set_reg (in_dst),
        .clr_en  (wb_valid),
        .clr_reg (wb_reg),
        .rd_a    (in_src_a),
        .rd_b    (in_src_b),
        .rd_d    (in_dst),
        .hit_a   (hit_a),
        .hit_b   (hit_b),
        .hit_d   (hit_d)
    );

    fp_ii_tracker #(.NCLS(NUM_CLASS)) u_gap (
        .clk   (clk),
        .rst_n (rst_n),
        .start (issue_grant),
        .op    (op),
        .hold  (gap_hold)
    );

    fp_wb_wheel #(.REG_W(REG_W), .DEPTH(DEPTH), .LAT_W(LAT_W)) u_wheel (
        .clk      (clk),
        .rst_n    (rst_n),
        .ins_lat  (lat),
        .ins_en   (issue_grant),
        .ins_reg  (in_dst),
        .collide  (slot_busy),
        .wb_valid (wb_valid),
        .wb_reg   (wb_reg)
    );

    // Combine all hold reasons into the grant.
    always_comb begin
        raw_hz      = hit_a | (reads_b(op) & hit_b);
        waw_hz      = hit_d;
        issue_grant = rst_n & in_valid & legal & ~raw_hz & ~waw_hz
                    & ~gap_hold & ~slot_busy;
    end

endmodule

// File: rtl/fp_issue_scoreboard_chk.sv
// Checker for fp_issue_scoreboard. It keeps its own pending-register
// shadow, built only from grants and strobes seen at the ports, and
// checks the grant and writeback rules against it.
module fp_issue_scoreboard_chk #(
    parameter int NREGS = 32,
    parameter int REG_W = $clog2(NREGS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [2:0]       in_op,
    input logic [REG_W-1:0] in_src_a,
    input logic [REG_W-1:0] in_dst,
    input logic             issue_grant,
    input logic             wb_valid,
    input logic [REG_W-1:0] wb_reg
);

    logic [NREGS-1:0] shadow;

    // Track pending registers from port activity only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow <= '0;
        end else begin
            if (wb_valid)
                shadow[wb_reg] <= 1'b0;
            if (issue_grant)
                shadow[in_dst] <= 1'b1;
        end
    end

    // R10
    grant_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_grant |-> in_valid);

    // R9
    rsvd_never_issued_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_grant |-> in_op != 3'd7);

    // R6
    no_waw_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_grant |-> !shadow[in_dst]);

    // R4
    no_raw_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_grant |-> !shadow[in_src_a]);

    // R7
    wb_of_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> shadow[wb_reg]);

    // R2
    neg_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_grant && in_op == 3'd4) |-> ##2 (wb_valid && wb_reg == $past(in_dst, 2)));

    // R3
    add_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_grant && in_op == 3'd0) |=> !(issue_grant && in_op == 3'd0)
                                           ##1 !(issue_grant && in_op == 3'd0));

endmodule

bind fp_issue_scoreboard fp_issue_scoreboard_chk #(.NREGS(NREGS), .REG_W(REG_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_op       (in_op),
    .in_src_a    (in_src_a),
    .in_dst      (in_dst),
    .issue_grant (issue_grant),
    .wb_valid    (wb_valid),
    .wb_reg      (wb_reg)
);

// File: tb/tb_fp_issue_scoreboard.sv
`timescale 1ns/1ps
// Bench: directed sweeps with a reference model of every expected strobe.
module tb_fp_issue_scoreboard;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [2:0] in_op = 3'd0;
    logic [4:0] in_src_a = 5'd0, in_src_b = 5'd0, in_dst = 5'd0;
    logic       issue_grant, wb_valid;
    logic [4:0] wb_reg;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int exp_at [32];

    fp_issue_scoreboard dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_src_a(in_src_a), .in_src_b(in_src_b), .in_dst(in_dst),
        .issue_grant(issue_grant), .wb_valid(wb_valid), .wb_reg(wb_reg)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int tb_lat(int op);
        case (op)
            0: return 4;   1: return 8;   2: return 36;  3: return 112;
            4: return 2;   5: return 2;   6: return 3;   default: return 0;
        endcase
    endfunction

    function automatic int tb_gap(int op);
        case (op)
            0: return 3;   1: return 4;   2: return 35;  3: return 111;
            4: return 1;   5: return 1;   6: return 2;   default: return 1;
        endcase
    endfunction

    // R2 reference: every strobe must match a scheduled completion, in its cycle.
    always begin
        @(negedge clk);
        #2;
        if (rst_n) begin
            if (wb_valid) begin
                checks++;
                if (exp_at[wb_reg] != cyc) begin
                    errors++;
                    $display("FAIL R2: strobe reg %0d at cycle %0d, expected cycle %0d",
                             wb_reg, cyc, exp_at[wb_reg]);
                end
                exp_at[wb_reg] = -1;
            end
            for (int r = 0; r < 32; r++) begin
                if (exp_at[r] >= 0 && exp_at[r] <= cyc) begin
                    checks++;
                    errors++;
                    $display("FAIL R2: reg %0d strobe missing at cycle %0d (actual none, expected %0d)",
                             r, cyc, exp_at[r]);
                    exp_at[r] = -1;
                end
            end
        end
    end

    task automatic check(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // Offer one instruction for one cycle and check the grant.
    task automatic try_op(input int op, input int a, input int b, input int d,
                          input logic exp, input string tag);
        in_valid = 1'b1;
        in_op    = 3'(op);
        in_src_a = 5'(a);
        in_src_b = 5'(b);
        in_dst   = 5'(d);
        #1;
        check(issue_grant, exp, tag);
        if (issue_grant)
            exp_at[d] = cyc + tb_lat(op);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: actual hung, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int r = 0; r < 32; r++) exp_at[r] = -1;

        // R1: no grant while reset is held, no strobe after it
        in_valid = 1'b1; in_op = 3'd4; in_dst = 5'd1;
        repeat (3) @(negedge clk);
        #1;
        check(issue_grant, 1'b0, "R1 grant in reset");
        rst_n = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);
        #1;
        check(wb_valid, 1'b0, "R1 strobe after reset");
        @(negedge clk);

        // R10: nothing offered, nothing granted
        in_valid = 1'b0; in_op = 3'd4; in_dst = 5'd2;
        #1;
        check(issue_grant, 1'b0, "R10 no valid");
        @(negedge clk);

        // R9: reserved class code with all resources free
        try_op(7, 20, 21, 3, 1'b0, "R9 reserved code");

        // R2 and R3: each class, then retry the same class on each gap offset
        for (int c = 0; c < 7; c++) begin
            try_op(c, 20, 21, 10, 1'b1, "R2 first start");
            for (int k = 1; k <= tb_gap(c); k++) begin
                if (k == tb_gap(c))
                    try_op(c, 20, 21, 11, 1'b1, "R3 gap end");
                else
                    try_op(c, 20, 21, 11, 1'b0, "R3 inside gap");
            end
            idle(120);
        end

        // R4 and R7: source A sweep over a multiply (strobe at offset 8)
        try_op(1, 20, 21, 5, 1'b1, "R4 producer");
        for (int k = 1; k <= 9; k++)
            try_op(0, 5, 22, 12, (k == 9), (k == 8) ? "R7 strobe cycle" : "R4 src a sweep");
        idle(20);

        // R4: source B sweep with compare
        try_op(1, 20, 21, 6, 1'b1, "R4 producer b");
        for (int k = 1; k <= 9; k++)
            try_op(6, 23, 6, 13, (k == 9), "R4 src b sweep");
        idle(20);

        // R5 and R6: single-operand classes ignore a pending second source
        try_op(2, 20, 21, 7, 1'b1, "R5 producer");
        try_op(4, 24, 7, 14, 1'b1, "R5 negate src b");
        try_op(3, 25, 7, 15, 1'b1, "R5 sqrt src b");
        try_op(5, 7, 26, 16, 1'b0, "R4 abs src a");
        try_op(4, 24, 25, 7, 1'b0, "R6 negate dst");
        try_op(6, 24, 25, 7, 1'b0, "R6 compare dst");
        idle(120);

        // R8: writeback slot collision
        try_op(0, 20, 21, 1, 1'b1, "R8 add");
        try_op(4, 20, 21, 2, 1'b1, "R8 negate early");
        try_op(4, 20, 21, 3, 1'b0, "R8 collide");
        try_op(4, 20, 21, 3, 1'b1, "R8 next slot");
        idle(20);

        // R11: different classes started back to back
        try_op(0, 20, 21, 1, 1'b1, "R11 add");
        try_op(1, 20, 21, 2, 1'b1, "R11 mul");
        try_op(6, 20, 21, 3, 1'b1, "R11 cmp");
        try_op(0, 20, 21, 4, 1'b1, "R11 add again");
        idle(20);

        // R2: every scheduled strobe has been seen
        for (int r = 0; r < 32; r++)
            check(exp_at[r] == -1, 1'b1, "R2 drained");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule